// File: doc/BRIEF.md
# Data Cache Miss Allocation Controller

This block sits beside the tag lookup of a four-way set-associative L1 data cache and decides, in the same cycle as the lookup, what a given access does to the cache. A load, store or prefetch-touch that misses may claim a line. The line comes from a tree pseudo-LRU walk that skips locked ways. The access may instead go straight to memory with no tag change, or it may do nothing because a fill already in flight covers its line. Cache-maintenance operations and snoops from other bus masters may raise an invalidate or a writeback (push) of a dirty line.

The block keeps one 3-bit pseudo-LRU tree per set and no other state. All outputs are combinational from the request and the tree of the addressed set. The tree of that set changes at the next rising clock edge when the access hits or allocates.

Top module: `dc_alloc_ctrl`

## Requirements
- R1: A valid load, touch or write-back store (op 0, 2 or 1) that is caching-allowed, not caching-inhibited (store also not write-through) and misses in all ways raises `alloc_req` with the victim chosen by the set's tree. Tree bit 0 picks the pair (0 selects ways 0/1, 1 selects ways 2/3). Bit 1 picks within ways 0/1 (0 selects way 0). Bit 2 picks within ways 2/3 (0 selects way 2).
- R2: With `cache_en` low or all four lock bits set, no allocation is raised. An eligible miss is then forwarded (`mem_fwd`), and the set's tree is left unchanged.
- R3: The victim walk never returns a locked way: a pair whose two ways are locked is abandoned for the other pair, and a locked leaf gives way to its sibling.
- R4: While `fill_match` is high, a miss neither allocates nor forwards.
- R5: A store miss that is write-through or caching-inhibited, and any caching-inhibited load miss, raises `mem_fwd` and never `alloc_req`.
- R6: Block invalidate (op 3) and block flush (op 4) that miss raise no output.
- R7: A write-back store that hits a line whose shared bit is set raises `inval_req` on the hit way and `treat_miss`, and is then handled as a miss. If that way is unlocked, the allocation reuses it. A write-through store hitting a shared line does none of this.
- R8: A snoop (op 5) that hits a modified line raises `push_req` on that way. Snoops never allocate and never change the tree.
- R9: A block invalidate that hits raises `inval_req` only. A block flush that hits raises `inval_req`, and also `push_req` when the line is modified.
- R10: Every load, store or touch hit and every allocation points the tree away from the way used. The next victim in that set differs from it.
- R11: A synchronous active-low reset sets every tree to zero, so way 0 is the first victim. With `req_valid` low every output is 0 and no tree changes. The way outputs read 0 whenever their request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_op | input | 3 | 0 load, 1 store, 2 touch, 3 block invalidate, 4 block flush, 5 snoop |
| req_cacheable | input | 1 | Caching-allowed attribute |
| req_wthru | input | 1 | Write-through attribute |
| req_inhibit | input | 1 | Caching-inhibited attribute |
| req_set | input | SET_W | Set index of the access |
| hit_vec | input | 4 | Per-way tag match |
| shared_vec | input | 4 | Per-way shared state |
| mod_vec | input | 4 | Per-way modified state |
| lock_vec | input | 4 | Per-way lock bits of the set |
| cache_en | input | 1 | Global cache enable |
| fill_match | input | 1 | A pending fill already covers this line |
| alloc_req | output | 1 | Allocate a line |
| alloc_way | output | 2 | Way to allocate |
| inval_req | output | 1 | Invalidate a line |
| inval_way | output | 2 | Way to invalidate |
| push_req | output | 1 | Write a dirty line back |
| push_way | output | 2 | Way to push |
| treat_miss | output | 1 | Hit downgraded to a miss |
| mem_fwd | output | 1 | Forward access to memory without tag change |

## Verification
The properties assume that the tag lookup never reports more than one hit way, and that caching-inhibited accesses never report a hit. They also assume that `req_valid` stays low while reset is held, so the temporal check on consecutive victims sees only real allocations. Every stimulus vector uses a hit vector with at most one bit set. Inhibited accesses are always driven as misses. The bench releases reset before it drives any request.

// File: rtl/dc_alloc_pkg.sv
// Shared types and tree pseudo-LRU helpers for the allocation controller.
// Assumes exactly four ways; the tree uses bit 0 as root, bit 1 for
// ways 0/1 and bit 2 for ways 2/3, each bit pointing at the victim side.
package dc_alloc_pkg;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int TREE_W = 3;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_TOUCH  = 3'd2,
        OP_BINV   = 3'd3,
        OP_BFLUSH = 3'd4,
        OP_SNOOP  = 3'd5
    } acc_op_e;

    // Index of the set bit of a one-hot (or zero) way vector.
    function automatic logic [WAY_W-1:0] way_index(input logic [WAYS-1:0] v);
        logic [WAY_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < WAYS; i++)
            if (v[i]) idx = WAY_W'(i);
        return idx;
    endfunction

    // Tree state after using a way: every bit on its path points away.
    function automatic logic [TREE_W-1:0] tree_touch(input logic [TREE_W-1:0] t,
                                                     input logic [WAY_W-1:0] w);
        logic [TREE_W-1:0] n;
        n    = t;
        n[0] = ~w[1];
        if (!w[1]) n[1] = ~w[0];
        else       n[2] = ~w[0];
        return n;
    endfunction
endpackage

// File: rtl/dc_tree_store.sv
// Per-set pseudo-LRU tree storage. One register per set; a combinational
// read port for the set under lookup and one update port. Assumes NUM_SETS
// is a power of two so every index value addresses a real set.
module dc_tree_store
    import dc_alloc_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    output logic [TREE_W-1:0] rd_tree,
    input  logic              upd_en,
    input  logic [WAY_W-1:0]  upd_way
);
    logic [TREE_W-1:0] tree_all [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [TREE_W-1:0] tree_q;
        // Holds the tree of one set; cleared by reset, touched on use.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tree_q <= '0;
            else if (upd_en && rd_set == SET_W'(s))
                tree_q <= tree_touch(tree_q, upd_way);
        end
        assign tree_all[s] = tree_q;
    end

    // Read port for the addressed set.
    always_comb rd_tree = tree_all[rd_set];
endmodule

// File: rtl/dc_victim_pick.sv
// Lock-aware tree walk. Returns the preferred way when it is enabled and
// unlocked, otherwise walks the tree, abandoning a fully locked pair and
// stepping to the sibling of a locked leaf. Assumes at least one way is
// unlocked whenever the result is used.
module dc_victim_pick
    import dc_alloc_pkg::*;
(
    input  logic [TREE_W-1:0] tree,
    input  logic [WAYS-1:0]   lock_vec,
    input  logic              pref_en,
    input  logic [WAY_W-1:0]  pref_way,
    output logic [WAY_W-1:0]  victim
);
    logic left_ok, right_ok, go_right;
    logic [WAY_W-1:0] tree_way;

    // Walk the tree with lock steering.
    always_comb begin
        left_ok  = !(lock_vec[0] && lock_vec[1]);
        right_ok = !(lock_vec[2] && lock_vec[3]);
        go_right = tree[0] ? right_ok : !left_ok;
        if (go_right)
            tree_way = tree[2] ? (lock_vec[3] ? 2'd2 : 2'd3)
                               : (lock_vec[2] ? 2'd3 : 2'd2);
        else
            tree_way = tree[1] ? (lock_vec[1] ? 2'd0 : 2'd1)
                               : (lock_vec[0] ? 2'd1 : 2'd0);
    end

    // Prefer the freed way when it is allowed.
    always_comb victim = (pref_en && !lock_vec[pref_way]) ? pref_way : tree_way;
endmodule

// File: rtl/dc_alloc_decide.sv
// Decision logic: classifies the access, applies the attribute, enable,
// lock and pending-fill gates, and produces every request plus the tree
// update. Assumes hit_vec has at most one bit set.
module dc_alloc_decide
    import dc_alloc_pkg::*;
(
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic              req_cacheable,
    input  logic              req_wthru,
    input  logic              req_inhibit,
    input  logic [WAYS-1:0]   hit_vec,
    input  logic [WAYS-1:0]   shared_vec,
    input  logic [WAYS-1:0]   mod_vec,
    input  logic [WAYS-1:0]   lock_vec,
    input  logic              cache_en,
    input  logic              fill_match,
    input  logic [WAY_W-1:0]  victim,
    output logic              pref_en,
    output logic [WAY_W-1:0]  hit_way,
    output logic              alloc_req,
    output logic [WAY_W-1:0]  alloc_way,
    output logic              inval_req,
    output logic [WAY_W-1:0]  inval_way,
    output logic              push_req,
    output logic [WAY_W-1:0]  push_way,
    output logic              treat_miss,
    output logic              mem_fwd,
    output logic              upd_en,
    output logic [WAY_W-1:0]  upd_way
);
    logic is_mem, is_store, is_blk, can_fill, hit, shared_st, eff_miss;

    // Classify the access and its attributes.
    always_comb begin
        is_store  = req_op == OP_STORE;
        is_mem    = req_op == OP_LOAD || is_store || req_op == OP_TOUCH;
        is_blk    = req_op == OP_BINV || req_op == OP_BFLUSH;
        can_fill  = req_cacheable && !req_inhibit && !(is_store && req_wthru);
        hit       = |hit_vec;
        hit_way   = way_index(hit_vec);
        shared_st = is_store && req_cacheable && !req_inhibit && !req_wthru
                    && |(hit_vec & shared_vec);
        eff_miss  = !hit || shared_st;
        pref_en   = shared_st;
    end

    // Produce requests and the tree update.
    always_comb begin
        alloc_req  = req_valid && is_mem && can_fill && eff_miss && cache_en
                     && !(&lock_vec) && !fill_match;
        alloc_way  = alloc_req ? victim : '0;
        treat_miss = req_valid && shared_st;
        inval_req  = req_valid && (shared_st || (is_blk && hit));
        inval_way  = inval_req ? hit_way : '0;
        push_req   = req_valid && |(hit_vec & mod_vec)
                     && (req_op == OP_SNOOP || req_op == OP_BFLUSH);
        push_way   = push_req ? hit_way : '0;
        mem_fwd    = req_valid && is_mem && eff_miss && !alloc_req && !fill_match;
        upd_en     = alloc_req || (req_valid && is_mem && hit && !shared_st);
        upd_way    = alloc_req ? victim : hit_way;
    end
endmodule

// File: rtl/dc_alloc_ctrl.sv
// Top of the data cache miss allocation controller. Wires the per-set
// tree store, the lock-aware victim walk and the decision logic. Outputs
// are combinational in the lookup cycle; the tree of the addressed set
// changes at the following rising edge.
module dc_alloc_ctrl
    import dc_alloc_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic              req_cacheable,
    input  logic              req_wthru,
    input  logic              req_inhibit,
    input  logic [SET_W-1:0]  req_set,
    input  logic [3:0]        hit_vec,
    input  logic [3:0]        shared_vec,
    input  logic [3:0]        mod_vec,
    input  logic [3:0]        lock_vec,
    input  logic              cache_en,
    input  logic              fill_match,
    output logic              alloc_req,
    output logic [1:0]        alloc_way,
    output logic              inval_req,
    output logic [1:0]        inval_way,
    output logic              push_req,
    output logic [1:0]        push_way,
    output logic              treat_miss,
    output logic              mem_fwd
);
    logic [TREE_W-1:0] tree;
    logic [WAY_W-1:0]  victim, hit_way, upd_way;
    logic              pref_en, upd_en;

    dc_tree_store #(.NUM_SETS(NUM_SETS)) i_store (
        .clk(clk), .rst_n(rst_n), .rd_set(req_set), .rd_tree(tree),
        .upd_en(upd_en), .upd_way(upd_way)
    );

    dc_victim_pick i_pick (
        .tree(tree), .lock_vec(lock_vec), .pref_en(pref_en),
        .pref_way(hit_way), .victim(victim)
    );

    dc_alloc_decide i_decide (
        .req_valid(req_valid), .req_op(req_op), .req_cacheable(req_cacheable),
        .req_wthru(req_wthru), .req_inhibit(req_inhibit), .hit_vec(hit_vec),
        .shared_vec(shared_vec), .mod_vec(mod_vec), .lock_vec(lock_vec),
        .cache_en(cache_en), .fill_match(fill_match), .victim(victim),
        .pref_en(pref_en), .hit_way(hit_way), .alloc_req(alloc_req),
        .alloc_way(alloc_way), .inval_req(inval_req), .inval_way(inval_way),
        .push_req(push_req), .push_way(push_way), .treat_miss(treat_miss),
        .mem_fwd(mem_fwd), .upd_en(upd_en), .upd_way(upd_way)
    );
endmodule

// File: rtl/dc_alloc_ctrl_chk.sv
// Property checker for dc_alloc_ctrl, attached by bind. Assumes one-hot
// or zero hit vectors and req_valid low while reset is held.
module dc_alloc_ctrl_chk #(
    parameter int SET_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic             req_cacheable,
    input logic             req_wthru,
    input logic             req_inhibit,
    input logic [SET_W-1:0] req_set,
    input logic [3:0]       hit_vec,
    input logic [3:0]       shared_vec,
    input logic [3:0]       mod_vec,
    input logic [3:0]       lock_vec,
    input logic             cache_en,
    input logic             fill_match,
    input logic             alloc_req,
    input logic [1:0]       alloc_way,
    input logic             inval_req,
    input logic [1:0]       inval_way,
    input logic             push_req,
    input logic [1:0]       push_way,
    input logic             treat_miss,
    input logic             mem_fwd
);
    a_r2_no_alloc_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (!cache_en || &lock_vec)) |-> !alloc_req);

    a_r3_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> !lock_vec[alloc_way]);

    a_r4_pending_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_match |-> (!alloc_req && !mem_fwd));

    a_r6_blockop_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd3 || req_op == 3'd4) && hit_vec == 4'd0)
        |-> !(alloc_req || mem_fwd || inval_req || push_req));

    a_r7_shared_store: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd1 && req_cacheable && !req_wthru && !req_inhibit
         && |(hit_vec & shared_vec)) |-> (inval_req && treat_miss && hit_vec[inval_way]));

    a_r8_push_needs_dirty_hit: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> ((req_op == 3'd5 || req_op == 3'd4) && mod_vec[push_way] && hit_vec[push_way]));

    a_r8_snoop_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 3'd5) |-> (!alloc_req && !mem_fwd));

    a_r10_victim_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alloc_req) && $past(!inval_req) && alloc_req && !inval_req
         && req_set == $past(req_set) && lock_vec == 4'd0 && $past(lock_vec) == 4'd0)
        |-> alloc_way != $past(alloc_way));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(alloc_req || inval_req || push_req || treat_miss || mem_fwd));

    a_r11_alloc_fwd_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_req && mem_fwd));
endmodule

bind dc_alloc_ctrl dc_alloc_ctrl_chk #(.SET_W(SET_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_cacheable(req_cacheable), .req_wthru(req_wthru), .req_inhibit(req_inhibit),
    .req_set(req_set), .hit_vec(hit_vec), .shared_vec(shared_vec), .mod_vec(mod_vec),
    .lock_vec(lock_vec), .cache_en(cache_en), .fill_match(fill_match),
    .alloc_req(alloc_req), .alloc_way(alloc_way), .inval_req(inval_req),
    .inval_way(inval_way), .push_req(push_req), .push_way(push_way),
    .treat_miss(treat_miss), .mem_fwd(mem_fwd)
);

// File: tb/test_dc_alloc_ctrl.sv
`timescale 1ns/1ps
module test_dc_alloc_ctrl;
    localparam int SET_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic req_cacheable = 1'b0, req_wthru = 1'b0, req_inhibit = 1'b0;
    logic [SET_W-1:0] req_set = '0;
    logic [3:0] hit_vec = '0, shared_vec = '0, mod_vec = '0, lock_vec = '0;
    logic cache_en = 1'b1, fill_match = 1'b0;
    logic alloc_req, inval_req, push_req, treat_miss, mem_fwd;
    logic [1:0] alloc_way, inval_way, push_way;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dc_alloc_ctrl #(.NUM_SETS(16)) i_dc_alloc_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_cacheable(req_cacheable), .req_wthru(req_wthru), .req_inhibit(req_inhibit),
        .req_set(req_set), .hit_vec(hit_vec), .shared_vec(shared_vec), .mod_vec(mod_vec),
        .lock_vec(lock_vec), .cache_en(cache_en), .fill_match(fill_match),
        .alloc_req(alloc_req), .alloc_way(alloc_way), .inval_req(inval_req),
        .inval_way(inval_way), .push_req(push_req), .push_way(push_way),
        .treat_miss(treat_miss), .mem_fwd(mem_fwd)
    );

    // Output bundle: {alloc, alloc_way, inval, inval_way, push, push_way, miss, fwd}
    typedef struct packed {
        logic [2:0]  op;
        logic        ca;
        logic        wt;
        logic        ci;
        logic [3:0]  set;
        logic [3:0]  hit;
        logic [3:0]  shr;
        logic [3:0]  mdf;
        logic [3:0]  lck;
        logic        en;
        logic        fm;
        logic [3:0]  req;
        logic [10:0] exp;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{3'd0,1'b1,1'b0,1'b0,4'd1, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd1, 11'b1_00_0_00_0_00_0_0}, // R1 first victim way 0
        '{3'd0,1'b1,1'b0,1'b0,4'd1, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd10,11'b1_10_0_00_0_00_0_0}, // R10 after way 0 -> way 2
        '{3'd1,1'b1,1'b0,1'b0,4'd2, 4'b0000,4'b0000,4'b0000,4'b0001,1'b1,1'b0,4'd3, 11'b1_01_0_00_0_00_0_0}, // R3 leaf sibling
        '{3'd0,1'b1,1'b0,1'b0,4'd3, 4'b0000,4'b0000,4'b0000,4'b0011,1'b1,1'b0,4'd3, 11'b1_10_0_00_0_00_0_0}, // R3 pair abandoned
        '{3'd0,1'b1,1'b0,1'b0,4'd4, 4'b0000,4'b0000,4'b0000,4'b0000,1'b0,1'b0,4'd2, 11'b0_00_0_00_0_00_0_1}, // R2 disabled
        '{3'd0,1'b1,1'b0,1'b0,4'd4, 4'b0000,4'b0000,4'b0000,4'b1111,1'b1,1'b0,4'd2, 11'b0_00_0_00_0_00_0_1}, // R2 all locked
        '{3'd1,1'b1,1'b1,1'b0,4'd5, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd5, 11'b0_00_0_00_0_00_0_1}, // R5 write-through store
        '{3'd1,1'b0,1'b0,1'b1,4'd5, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd5, 11'b0_00_0_00_0_00_0_1}, // R5 inhibited store
        '{3'd0,1'b1,1'b0,1'b0,4'd5, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b1,4'd4, 11'b0_00_0_00_0_00_0_0}, // R4 pending fill
        '{3'd3,1'b1,1'b0,1'b0,4'd6, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd6, 11'b0_00_0_00_0_00_0_0}, // R6 block inv miss
        '{3'd4,1'b1,1'b0,1'b0,4'd6, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd6, 11'b0_00_0_00_0_00_0_0}, // R6 block flush miss
        '{3'd1,1'b1,1'b0,1'b0,4'd7, 4'b0100,4'b0100,4'b0000,4'b0000,1'b1,1'b0,4'd7, 11'b1_10_1_10_0_00_1_0}, // R7 reuse freed way
        '{3'd1,1'b1,1'b0,1'b0,4'd8, 4'b0010,4'b0010,4'b0000,4'b0010,1'b1,1'b0,4'd7, 11'b1_00_1_01_0_00_1_0}, // R7 freed way locked
        '{3'd5,1'b1,1'b0,1'b0,4'd9, 4'b1000,4'b0000,4'b1000,4'b0000,1'b1,1'b0,4'd8, 11'b0_00_0_00_1_11_0_0}, // R8 snoop dirty hit
        '{3'd5,1'b1,1'b0,1'b0,4'd9, 4'b1000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd8, 11'b0_00_0_00_0_00_0_0}, // R8 snoop clean hit
        '{3'd5,1'b1,1'b0,1'b0,4'd9, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd8, 11'b0_00_0_00_0_00_0_0}, // R8 snoop miss
        '{3'd0,1'b1,1'b0,1'b0,4'd9, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd8, 11'b1_00_0_00_0_00_0_0}, // R8 tree untouched
        '{3'd3,1'b1,1'b0,1'b0,4'd10,4'b0001,4'b0000,4'b0001,4'b0000,1'b1,1'b0,4'd9, 11'b0_00_1_00_0_00_0_0}, // R9 inv hit
        '{3'd4,1'b1,1'b0,1'b0,4'd10,4'b0010,4'b0000,4'b0010,4'b0000,1'b1,1'b0,4'd9, 11'b0_00_1_01_1_01_0_0}, // R9 flush dirty hit
        '{3'd0,1'b1,1'b0,1'b0,4'd11,4'b0001,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd10,11'b0_00_0_00_0_00_0_0}, // R10 load hit
        '{3'd0,1'b1,1'b0,1'b0,4'd11,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd10,11'b1_10_0_00_0_00_0_0}, // R10 hit moved tree
        '{3'd1,1'b1,1'b1,1'b0,4'd12,4'b0001,4'b0001,4'b0000,4'b0000,1'b1,1'b0,4'd7, 11'b0_00_0_00_0_00_0_0}, // R7 write-through shared
        '{3'd2,1'b1,1'b0,1'b0,4'd13,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd1, 11'b1_00_0_00_0_00_0_0}, // R1 touch
        '{3'd0,1'b1,1'b0,1'b0,4'd4, 4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd2, 11'b1_00_0_00_0_00_0_0}, // R2 blocked left tree alone
        '{3'd1,1'b1,1'b0,1'b0,4'd14,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd1, 11'b1_00_0_00_0_00_0_0}, // R1 write-back store
        '{3'd1,1'b1,1'b0,1'b0,4'd7, 4'b0100,4'b0100,4'b0000,4'b1111,1'b1,1'b0,4'd7, 11'b0_00_1_10_0_00_1_1}, // R7 shared, all locked
        '{3'd0,1'b0,1'b0,1'b1,4'd15,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,1'b0,4'd5, 11'b0_00_0_00_0_00_0_1}  // R5 inhibited load
    };

    function automatic logic [10:0] got();
        return {alloc_req, alloc_way, inval_req, inval_way, push_req, push_way,
                treat_miss, mem_fwd};
    endfunction

    task automatic check(input int rq, input logic [10:0] exp, input string what);
        checks++;
        if (got() !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%b expected=%b", rq, what, got(), exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_op = v.op; req_cacheable = v.ca; req_wthru = v.wt;
        req_inhibit = v.ci; req_set = v.set; hit_vec = v.hit; shared_vec = v.shr;
        mod_vec = v.mdf; lock_vec = v.lck; cache_en = v.en; fill_match = v.fm;
        #1;
    endtask

    function automatic vec_t load_miss(input logic [3:0] s);
        vec_t v;
        v = '{3'd0,1'b1,1'b0,1'b0,s,4'b0,4'b0,4'b0,4'b0,1'b1,1'b0,4'd11,11'b0};
        return v;
    endfunction

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(11, 11'b0, "outputs during reset");          // R11
        @(negedge clk);
        rst_n = 1'b1;
        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            check(int'(TBL[i].req), TBL[i].exp, $sformatf("vector %0d", i));
        end
        // R11: idle cycle with junk inputs is quiet and leaves set 2 alone
        drive(load_miss(4'd2));
        req_valid = 1'b0; hit_vec = 4'b0001; mod_vec = 4'b0001; req_op = 3'd5;
        #0.5;
        check(11, 11'b0, "idle with valid low");
        drive(load_miss(4'd1));
        check(11, 11'b1_01_0_00_0_00_0_0, "set 1 third victim before reset"); // R10
        // R11: reset restores every tree; set 1 victim back to way 0
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(load_miss(4'd1));
        check(11, 11'b1_00_0_00_0_00_0_0, "set 1 after reset");
        drive(load_miss(4'd11));
        check(11, 11'b1_00_0_00_0_00_0_0, "set 11 after reset");
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule